// File: doc/BRIEF.md
# Function-Unit Dependency Matrix

This block keeps, for each of `NUM_FU` function units, a private record of which other units it must wait on. When a unit is issued, its row takes a snapshot of two vectors offered by the register-level logic: the units with a pending write that the new instruction depends on, which it must wait on before reading operands, and the units with a pending read of its destination, which must read first before it writes. From then on the row changes only as other units report progress. It does not recompute from the live pending vectors.

Each row is a three-state machine. `ROW_FREE` moves to `ROW_READ` on an accepted issue. `ROW_READ` moves to `ROW_WRITE` when the unit reports its read while read permission is granted. `ROW_WRITE` moves back to `ROW_FREE` when the unit reports its write while write permission is granted. A read-done strobe from unit j clears bit j of every row's read-wait field. A write-done strobe from unit j clears bit j of every row's write-wait field. The diagonal of the matrix is tied to zero, so an instruction whose source and destination are the same register never waits on itself.

Top module: `fu_dep_matrix`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every `go_rd_o` and `go_wr_o` bit is 0 and no unit holds a dependency.
- R2: An issue to a unit in `ROW_FREE` is accepted at the clock edge. Its `go_rd_o` bit stays 0 in the issue cycle and is 1 in the next cycle if no write-wait bit was captured.
- R3: At an accepted issue, `wr_pend_i` (bit j = unit j) is copied into the row's write-wait field and `rd_pend_i` into its read-wait field. Later values on these inputs have no effect on that row.
- R4: Bit i of `rd_pend_i` and `wr_pend_i` is ignored when unit i issues.
- R5: `go_rd_o[i]` stays 1 until unit i strobes `rd_done_i[i]`. A `rd_done_i[i]` strobe while `go_rd_o[i]` is 0 does not change the unit's phase.
- R6: A `rd_done_i[i]` strobe while `go_rd_o[i]` is 1 moves unit i to `ROW_WRITE`. In the next cycle `go_rd_o[i]` is 0, and `go_wr_o[i]` is 1 once its read-wait field is empty.
- R7: `wr_done_i[j]` clears bit j of every write-wait field, and `rd_done_i[j]` clears bit j of every read-wait field, with effect in the next cycle.
- R8: `go_wr_o[i]` stays 1 until `wr_done_i[i]`. That strobe returns unit i to `ROW_FREE`, and both of its ready bits are 0 in the next cycle.
- R9: A done strobe from unit j in the same cycle that another unit issues with bit j set in its snapshot is honoured: that bit is not recorded.
- R10: An issue to a unit that is not in `ROW_FREE` is ignored, and its snapshot is left unchanged.
- R11: `go_rd_o[i]` and `go_wr_o[i]` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | NUM_FU | Issue strobe per unit |
| rd_pend_i | input | NUM_FU | Units that must read before the issuing unit writes |
| wr_pend_i | input | NUM_FU | Units whose write the issuing unit must wait for |
| rd_done_i | input | NUM_FU | Operand-read completion strobe per unit |
| wr_done_i | input | NUM_FU | Result-write completion strobe per unit |
| go_rd_o | output | NUM_FU | Permission to read operands, per unit |
| go_wr_o | output | NUM_FU | Permission to write the result, per unit |

## Verification
A stuck or wrongly loaded wait bit shows up one cycle after the issue or done strobe that should have changed it: a ready bit stays low when the waited-on unit has finished, or rises early. A row whose state has gone wrong shows both ready bits high, loses read permission without a done strobe, or starts reading again after a rejected issue. All of these appear within a cycle of the triggering event. The directed scenarios create each such event on purpose and sample the ready vectors in the following cycle.

// File: rtl/fudep_pkg.sv
package fudep_pkg;
    typedef enum logic [1:0] {
        ROW_FREE  = 2'd0,
        ROW_READ  = 2'd1,
        ROW_WRITE = 2'd2
    } row_state_t;
endpackage

// File: rtl/fudep_cell.sv
// One wait bit: loaded from the issue snapshot, cleared by a done strobe.
module fudep_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic snap,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (load)
            q <= snap & ~clr;   // a done in the issue cycle wins
        else if (clr)
            q <= 1'b0;
    end
endmodule

// File: rtl/fudep_row.sv
// One row of the matrix: wait fields for one unit plus its phase machine.
module fudep_row
    import fudep_pkg::*;
#(
    parameter int N   = 4,
    parameter int ROW = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [N-1:0] rd_snap,
    input  logic [N-1:0] wr_snap,
    input  logic [N-1:0] rd_done,
    input  logic [N-1:0] wr_done,
    output logic         go_rd,
    output logic         go_wr
);
    row_state_t   state_q, state_d;
    logic [N-1:0] rd_wait;
    logic [N-1:0] wr_wait;
    logic         accept;
    logic         diag_unused;

    assign accept = issue && (state_q == ROW_FREE);

    for (genvar j = 0; j < N; j++) begin : g_col
        if (j == ROW) begin : g_diag
            assign rd_wait[j] = 1'b0;
            assign wr_wait[j] = 1'b0;
        end else begin : g_cell
            fudep_cell u_rd (
                .clk  (clk),
                .rst_n(rst_n),
                .load (accept),
                .snap (rd_snap[j]),
                .clr  (rd_done[j]),
                .q    (rd_wait[j])
            );
            fudep_cell u_wr (
                .clk  (clk),
                .rst_n(rst_n),
                .load (accept),
                .snap (wr_snap[j]),
                .clr  (wr_done[j]),
                .q    (wr_wait[j])
            );
        end
    end

    assign diag_unused = rd_snap[ROW] ^ wr_snap[ROW];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROW_FREE:  if (issue)                 state_d = ROW_READ;
            ROW_READ:  if (rd_done[ROW] && go_rd) state_d = ROW_WRITE;
            ROW_WRITE: if (wr_done[ROW] && go_wr) state_d = ROW_FREE;
            default:                              state_d = ROW_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ROW_FREE;
        else
            state_q <= state_d;
    end

    always_comb begin
        go_rd = (state_q == ROW_READ)  && (wr_wait == '0);
        go_wr = (state_q == ROW_WRITE) && (rd_wait == '0);
    end
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
    parameter int NUM_FU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FU-1:0] issue_i,
    input  logic [NUM_FU-1:0] rd_pend_i,
    input  logic [NUM_FU-1:0] wr_pend_i,
    input  logic [NUM_FU-1:0] rd_done_i,
    input  logic [NUM_FU-1:0] wr_done_i,
    output logic [NUM_FU-1:0] go_rd_o,
    output logic [NUM_FU-1:0] go_wr_o
);
    for (genvar i = 0; i < NUM_FU; i++) begin : g_row
        fudep_row #(
            .N  (NUM_FU),
            .ROW(i)
        ) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .issue  (issue_i[i]),
            .rd_snap(rd_pend_i),
            .wr_snap(wr_pend_i),
            .rd_done(rd_done_i),
            .wr_done(wr_done_i),
            .go_rd  (go_rd_o[i]),
            .go_wr  (go_wr_o[i])
        );
    end
endmodule

// File: rtl/fudep_chk.sv
module fudep_chk #(
    parameter int NUM_FU = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_FU-1:0] rd_done_i,
    input logic [NUM_FU-1:0] wr_done_i,
    input logic [NUM_FU-1:0] go_rd_o,
    input logic [NUM_FU-1:0] go_wr_o
);
    for (genvar j = 0; j < NUM_FU; j++) begin : g_fu
        // R11
        excl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(go_rd_o[j] && go_wr_o[j]));
        // R5
        rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            go_rd_o[j] && !rd_done_i[j] |=> go_rd_o[j]);
        // R6
        rd_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
            go_rd_o[j] && rd_done_i[j] |=> !go_rd_o[j]);
        // R8
        wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            go_wr_o[j] && !wr_done_i[j] |=> go_wr_o[j]);
        // R8
        wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            go_wr_o[j] && wr_done_i[j] |=> !go_wr_o[j] && !go_rd_o[j]);
    end
endmodule

bind fu_dep_matrix fudep_chk #(.NUM_FU(NUM_FU)) u_fudep_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_done_i(rd_done_i),
    .wr_done_i(wr_done_i),
    .go_rd_o  (go_rd_o),
    .go_wr_o  (go_wr_o)
);

// File: tb/test_fu_dep_matrix.sv
module test_fu_dep_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] issue_i, rd_pend_i, wr_pend_i, rd_done_i, wr_done_i;
    logic [N-1:0] go_rd_o, go_wr_o;
    int tests = 0;
    int fails = 0;

    fu_dep_matrix #(.NUM_FU(N)) i_fu_dep_matrix (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i),
        .rd_pend_i(rd_pend_i), .wr_pend_i(wr_pend_i),
        .rd_done_i(rd_done_i), .wr_done_i(wr_done_i),
        .go_rd_o(go_rd_o), .go_wr_o(go_wr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        issue_i = '0; rd_done_i = '0; wr_done_i = '0;
        rd_pend_i = '0; wr_pend_i = '0;
    endtask

    task automatic do_reset();
        clear_strobes();
        rst_n = 1'b0;
        tick();
        check("R1 rd in reset", go_rd_o, 4'b0000);
        check("R1 wr in reset", go_wr_o, 4'b0000);
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 rd after reset", go_rd_o, 4'b0000);
        check("R1 wr after reset", go_wr_o, 4'b0000);
    endtask

    // R2 R6 R8: plain pass through all phases
    task automatic t_basic();
        do_reset();
        issue_i = 4'b0001;
        #1 check("R2 same cycle", go_rd_o, 4'b0000);
        tick(); clear_strobes();
        check("R2 go_rd next cycle", go_rd_o, 4'b0001);
        rd_done_i = 4'b0001; tick(); clear_strobes();
        check("R6 go_rd dropped", go_rd_o, 4'b0000);
        check("R6 go_wr raised", go_wr_o, 4'b0001);
        wr_done_i = 4'b0001; tick(); clear_strobes();
        check("R8 freed rd", go_rd_o, 4'b0000);
        check("R8 freed wr", go_wr_o, 4'b0000);
    endtask

    // R4: self bits ignored
    task automatic t_self();
        do_reset();
        issue_i = 4'b0010; rd_pend_i = 4'b0010; wr_pend_i = 4'b0010;
        tick(); clear_strobes();
        check("R4 self write-wait ignored", go_rd_o, 4'b0010);
        rd_done_i = 4'b0010; tick(); clear_strobes();
        check("R4 self read-wait ignored", go_wr_o, 4'b0010);
    endtask

    // R3 R5 R7: read-after-write wait, snapshot held, early rd_done ignored
    task automatic t_raw();
        do_reset();
        issue_i = 4'b0001; tick(); clear_strobes();
        issue_i = 4'b0100; wr_pend_i = 4'b0001; tick(); clear_strobes();
        check("R3 FU2 waits on FU0 write", go_rd_o, 4'b0001);
        rd_pend_i = 4'b1111; wr_pend_i = 4'b0000; tick();
        check("R3 later pend inputs ignored", go_rd_o, 4'b0001);
        clear_strobes();
        rd_done_i = 4'b0100; tick(); clear_strobes();
        check("R5 early rd_done no phase change", go_wr_o, 4'b0000);
        rd_done_i = 4'b0001; tick(); clear_strobes();
        check("R7 read done alone keeps FU2 waiting", go_rd_o, 4'b0000);
        check("R6 FU0 write phase", go_wr_o, 4'b0001);
        wr_done_i = 4'b0001; tick(); clear_strobes();
        check("R7 write done releases FU2", go_rd_o, 4'b0100);
        check("R5 FU2 still in read phase", go_wr_o, 4'b0000);
    endtask

    // R7 R10: write-after-read wait, issue to busy unit ignored
    task automatic t_war();
        do_reset();
        issue_i = 4'b0100; tick(); clear_strobes();
        issue_i = 4'b1000; rd_pend_i = 4'b0100; tick(); clear_strobes();
        check("R3 FU3 reads at once", go_rd_o, 4'b1100);
        rd_done_i = 4'b1000; tick(); clear_strobes();
        check("R7 FU3 waits for FU2 read", go_wr_o, 4'b0000);
        check("R6 FU3 left read phase", go_rd_o, 4'b0100);
        issue_i = 4'b1000; tick(); clear_strobes();
        check("R10 busy issue ignored rd", go_rd_o, 4'b0100);
        check("R10 busy issue ignored wr", go_wr_o, 4'b0000);
        rd_done_i = 4'b0100; tick(); clear_strobes();
        check("R7 read done releases FU3", go_wr_o, 4'b1100);
        check("R6 no read permission left", go_rd_o, 4'b0000);
    endtask

    // R9: done in the same cycle as issue
    task automatic t_same_cycle();
        do_reset();
        issue_i = 4'b0001; tick(); clear_strobes();
        rd_done_i = 4'b0001; tick(); clear_strobes();
        check("R6 FU0 write phase", go_wr_o, 4'b0001);
        issue_i = 4'b0010; wr_pend_i = 4'b0001; wr_done_i = 4'b0001;
        tick(); clear_strobes();
        check("R9 dependency not recorded", go_rd_o, 4'b0010);
        check("R8 FU0 freed", go_wr_o, 4'b0000);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_basic();
        t_self();
        t_raw();
        t_war();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule